// File: doc/BRIEF.md
# Fetch-Execute Sequencer with Condition Flags

This block steps through a stored program on a 32-bit register machine with eight general registers. Each instruction names at most one word in memory. After a start pulse it loads the supplied address into its program counter. It then repeats a simple pattern: read the instruction word at the program counter, hold it in an instruction register, and carry it out. Memory is reached through one synchronous port that uses byte addresses and returns read data one cycle after the request. A halt instruction ends the program, and the block raises `done` until it is started again.

Arithmetic instructions leave four condition flags in a status register: negative, zero, signed overflow and carry-out. The conditional branch reads these flags from the last arithmetic instruction. This lets a program run a counted loop, for example one that adds a list of numbers. Such a loop can step through the list by rewriting its own operand address, because the only addressing mode is absolute.

The controller is a state machine with six states.
- `S_IDLE` waits for `start`, and `S_IDLE -> S_FETCH` on start.
- `S_FETCH` issues the instruction read, and `S_FETCH -> S_IWAIT` always.
- `S_IWAIT` captures the word into the instruction register, and `S_IWAIT -> S_EXEC` always.
- `S_EXEC` carries out the instruction:
  - `S_EXEC -> S_OPWAIT` for load and add;
  - `S_EXEC -> S_DONE` for halt;
  - `S_EXEC -> S_FETCH` for everything else.
- `S_OPWAIT` takes the operand word, and `S_OPWAIT -> S_FETCH` always.
- `S_DONE` holds `done`, and `S_DONE -> S_FETCH` on start.

Top module: `fx_sequencer`

## Requirements
- R1: During and after reset, `done` is 0, no memory access is made and `cond_flags` reads 0; the block stays idle until `start`.
- R2: When `start` is seen in the idle or done state, the program counter takes `start_addr`. The next cycle is a fetch read at that address.
- R3: An instruction word holds the opcode in bits [31:28], the register index in bits [26:24] (bit 27 is ignored) and an absolute byte address or branch target in bits [15:0]. The opcodes are 0 halt, 1 load, 2 store, 3 add, 4 clear, 5 decrement and 6 branch-if-greater-than-zero. Any other opcode only advances the program counter. After each non-branch, non-halt instruction the program counter grows by 4.
- R4: The bus sequence is fixed. A fetch read is followed by one quiet cycle and then the execute cycle. Load and add issue their operand read in the execute cycle and add one more quiet cycle. Read and write are never both high, and each read is followed by a quiet cycle.
- R5: Load copies the memory word into the register. Store writes the register value to the address during its execute cycle.
- R6: Add sets register = register + memory word. It sets the flags to N = result bit 31, Z = (result == 0), V = signed overflow and C = carry-out of bit 31. `cond_flags` is {N,Z,V,C} in bits [3:0].
- R7: Decrement sets register = register - 1. Its flags are those of adding all-ones: C is 1 unless the operand was 0, and V is 1 only when the operand was 0x80000000.
- R8: Clear sets the register to 0 and the flags to N=0, Z=1, V=0, C=0.
- R9: Load, store, branch, halt and unknown opcodes leave the flags unchanged. Flags change only at the end of an execute or operand-wait cycle.
- R10: The branch loads its target into the program counter when N and Z are both 0. Otherwise the program counter grows by 4.
- R11: After halt, `done` stays 1 with no memory access and stable flags until the next `start`. A `start` pulse while a program is running is ignored.
- R12: A loop that adds n list words, using decrement and branch and rewriting its own operand address, stores the correct sum and a pass count equal to n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, accepted in the idle or done state |
| start_addr | input | 16 | Byte address of the first instruction |
| mem_addr | output | 16 | Byte address for the memory access |
| mem_rd | output | 1 | Read request; data returns on the next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_rd` |
| done | output | 1 | High after a halt until the next start |
| cond_flags | output | 4 | Status flags {N,Z,V,C} |

## Verification
The bench runs three programs.

- **Summing loop, n = 5.** It starts at address 0 with mixed-sign values. It separates a taken branch from a not-taken one and shows that the decrement, not the earlier add, drives the decision.
- **Summing loop, n = 1.** It starts at 0x40 and has a start pulse injected mid-run. It tells a single-pass loop apart from one that branches back wrongly, and shows whether a running program restarts.
- **Flag program.** It starts at 0x80. It drives add into signed overflow and into a carry-out with a zero result, drives decrement across zero and across the most negative value, and ends with a taken branch that skips a store. It also includes an unknown opcode.

For all three programs, the bus activity and flags are compared each cycle against a behavioural interpreter.

// File: rtl/fx_pkg.sv
package fx_pkg;

    typedef enum logic [3:0] {
        OP_HALT  = 4'd0,
        OP_LOAD  = 4'd1,
        OP_STORE = 4'd2,
        OP_ADD   = 4'd3,
        OP_CLR   = 4'd4,
        OP_DEC   = 4'd5,
        OP_BGT   = 4'd6
    } opcode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_IWAIT,
        S_EXEC,
        S_OPWAIT,
        S_DONE
    } state_e;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_DEC,
        ALU_CLR
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/fx_regfile.sv
module fx_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 8,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata = regs[raddr];

endmodule

// File: rtl/fx_alu.sv
module fx_alu
    import fx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output flags_t            flags
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] sum_add;
    logic [DATA_W:0] sum_dec;

    assign sum_add = {1'b0, a} + {1'b0, b};
    assign sum_dec = {1'b0, a} + {1'b0, {DATA_W{1'b1}}};

    always_comb begin
        result  = b;
        flags.v = 1'b0;
        flags.c = 1'b0;
        unique case (op)
            ALU_ADD: begin
                result  = sum_add[MSB:0];
                flags.c = sum_add[DATA_W];
                flags.v = (a[MSB] == b[MSB]) && (sum_add[MSB] != a[MSB]);
            end
            ALU_DEC: begin
                result  = sum_dec[MSB:0];
                flags.c = sum_dec[DATA_W];
                flags.v = a[MSB] && !sum_dec[MSB];
            end
            ALU_CLR: begin
                result = '0;
            end
            default: begin
                result = b;
            end
        endcase
        flags.n = result[MSB];
        flags.z = (result == '0);
    end

endmodule

// File: rtl/fx_ctrl.sv
module fx_ctrl
    import fx_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 16,
    parameter int NREG        = 8,
    parameter int INSTR_BYTES = 4,
    localparam int REG_W      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output flags_t            flags_q,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_idx,
    output alu_op_e           alu_op,
    input  flags_t            alu_flags
);

    localparam int OPC_HI = DATA_W - 1;
    localparam int IDX_LO = DATA_W - 8;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    state_e            state;
    state_e            nxt;
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] ir;
    opcode_e           opc;
    logic [ADDR_W-1:0] target;
    logic              take_branch;

    assign opc         = opcode_e'(ir[OPC_HI -: 4]);
    assign rf_idx      = ir[IDX_LO +: REG_W];
    assign target      = ir[ADDR_W-1:0];
    assign take_branch = !flags_q.n && !flags_q.z;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = S_FETCH;
            S_FETCH:  nxt = S_IWAIT;
            S_IWAIT:  nxt = S_EXEC;
            S_EXEC: begin
                unique case (opc)
                    OP_LOAD, OP_ADD: nxt = S_OPWAIT;
                    OP_HALT:         nxt = S_DONE;
                    default:         nxt = S_FETCH;
                endcase
            end
            S_OPWAIT: nxt = S_FETCH;
            S_DONE:   if (start) nxt = S_FETCH;
            default:  nxt = S_IDLE;
        endcase
    end

    // program counter, instruction register, status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc      <= '0;
            ir      <= '0;
            flags_q <= '0;
        end else begin
            unique case (state)
                S_IDLE, S_DONE: begin
                    if (start) pc <= start_addr;
                end
                S_IWAIT: ir <= mem_rdata;
                S_EXEC: begin
                    unique case (opc)
                        OP_LOAD, OP_ADD, OP_HALT: ;
                        OP_BGT:  pc <= take_branch ? target : pc + STEP;
                        OP_CLR, OP_DEC: begin
                            pc      <= pc + STEP;
                            flags_q <= alu_flags;
                        end
                        default: pc <= pc + STEP;
                    endcase
                end
                S_OPWAIT: begin
                    pc <= pc + STEP;
                    if (opc == OP_ADD) flags_q <= alu_flags;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        mem_addr = target;
        rf_we    = 1'b0;
        alu_op   = ALU_PASS;
        done     = 1'b0;
        unique case (state)
            S_FETCH: begin
                mem_rd   = 1'b1;
                mem_addr = pc;
            end
            S_EXEC: begin
                unique case (opc)
                    OP_LOAD, OP_ADD: mem_rd = 1'b1;
                    OP_STORE:        mem_wr = 1'b1;
                    OP_CLR: begin
                        rf_we  = 1'b1;
                        alu_op = ALU_CLR;
                    end
                    OP_DEC: begin
                        rf_we  = 1'b1;
                        alu_op = ALU_DEC;
                    end
                    default: ;
                endcase
            end
            S_OPWAIT: begin
                rf_we  = 1'b1;
                alu_op = (opc == OP_ADD) ? ALU_ADD : ALU_PASS;
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/fx_sequencer.sv
module fx_sequencer
    import fx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int NREG   = 8,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [3:0]        cond_flags
);

    flags_t            flags_q;
    flags_t            alu_flags;
    alu_op_e           alu_op;
    logic              rf_we;
    logic [REG_W-1:0]  rf_idx;
    logic [DATA_W-1:0] rf_rdata;
    logic [DATA_W-1:0] alu_result;

    fx_ctrl #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .NREG  (NREG)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_addr(start_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .done      (done),
        .flags_q   (flags_q),
        .rf_we     (rf_we),
        .rf_idx    (rf_idx),
        .alu_op    (alu_op),
        .alu_flags (alu_flags)
    );

    fx_regfile #(
        .DATA_W(DATA_W),
        .NREG  (NREG)
    ) i_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (rf_we),
        .waddr(rf_idx),
        .wdata(alu_result),
        .raddr(rf_idx),
        .rdata(rf_rdata)
    );

    fx_alu #(
        .DATA_W(DATA_W)
    ) i_alu (
        .op    (alu_op),
        .a     (rf_rdata),
        .b     (mem_rdata),
        .result(alu_result),
        .flags (alu_flags)
    );

    assign mem_wdata  = rf_rdata;
    assign cond_flags = flags_q;

endmodule

// File: rtl/fx_sequencer_sva.sv
module fx_sequencer_sva #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              done,
    input logic [3:0]        cond_flags
);

    p_excl_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_read_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !mem_wr));

    p_store_then_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> mem_rd);

    p_start_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (mem_rd && mem_addr == $past(start_addr)));

    p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_rd && !mem_wr));

    p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(cond_flags)));

    p_nz_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cond_flags[3] && cond_flags[2]));

    p_flag_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_flags != $past(cond_flags)) |->
            (!$past(mem_rd) && !$past(mem_wr) && !$past(done)));

endmodule

bind fx_sequencer fx_sequencer_sva #(.ADDR_W(ADDR_W)) i_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_addr(start_addr),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .done      (done),
    .cond_flags(cond_flags)
);

// File: tb/test_fx_sequencer.sv
module test_fx_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_addr = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [3:0]  cond_flags;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fx_sequencer i_fx_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_addr(start_addr),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .done      (done),
        .cond_flags(cond_flags)
    );

    // memory seen by the design, and the reference model's own copy
    logic [31:0] mem  [128];
    logic [31:0] rmem [128];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[8:2]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[8:2]];
    end

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic        dn;
        logic [3:0]  fl;
    } rec_t;

    rec_t        exp_q[$];
    logic [31:0] m_r [8];
    logic [3:0]  m_f = 4'b0000;
    logic [31:0] lst [16];

    localparam logic [15:0] A_N = 16'h100, A_ONE = 16'h108, A_SUM = 16'h10C,
                            A_CNT = 16'h110, A_FOUR = 16'h104, A_LIST = 16'h140;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ins(input int op, input int r, input logic [15:0] a);
        return {op[3:0], 1'b0, r[2:0], 8'h00, a};
    endfunction

    task automatic poke(input logic [15:0] a, input logic [31:0] v);
        mem[a[8:2]]  = v;
        rmem[a[8:2]] = v;
    endtask

    function automatic void push(input logic rd, input logic wr, input logic [15:0] a,
                                 input logic [31:0] wd, input logic dn);
        rec_t e;
        e.rd = rd; e.wr = wr; e.addr = a; e.wdata = wd; e.dn = dn; e.fl = m_f;
        exp_q.push_back(e);
    endfunction

    // behavioural interpreter producing the expected per-cycle bus record
    task automatic model_run(input logic [15:0] sa);
        logic [15:0] pc = sa;
        bit halted = 0;
        for (int step = 0; step < 4000 && !halted; step++) begin
            logic [31:0] w = rmem[pc[8:2]];
            int op = int'(w[31:28]);
            int r = int'(w[26:24]);
            logic [15:0] a = w[15:0];
            longint s;
            logic [31:0] res;
            push(1, 0, pc, 0, 0);
            push(0, 0, 0, 0, 0);
            case (op)
                1: begin
                    push(1, 0, a, 0, 0); push(0, 0, 0, 0, 0);
                    m_r[r] = rmem[a[8:2]]; pc += 16'd4;
                end
                2: begin
                    push(0, 1, a, m_r[r], 0);
                    rmem[a[8:2]] = m_r[r]; pc += 16'd4;
                end
                3: begin
                    push(1, 0, a, 0, 0); push(0, 0, 0, 0, 0);
                    s = longint'(m_r[r]) + longint'(rmem[a[8:2]]);
                    res = s[31:0];
                    m_f = {res[31], res == 0,
                           (m_r[r][31] == rmem[a[8:2]][31]) && (res[31] != m_r[r][31]),
                           s[32]};
                    m_r[r] = res; pc += 16'd4;
                end
                4: begin
                    push(0, 0, 0, 0, 0);
                    m_r[r] = 0; m_f = 4'b0100; pc += 16'd4;
                end
                5: begin
                    push(0, 0, 0, 0, 0);
                    res = m_r[r] - 1;
                    m_f = {res[31], res == 0, m_r[r] == 32'h8000_0000, m_r[r] != 0};
                    m_r[r] = res; pc += 16'd4;
                end
                6: begin
                    push(0, 0, 0, 0, 0);
                    if (!m_f[3] && !m_f[2]) pc = a; else pc += 16'd4;
                end
                0: begin
                    push(0, 0, 0, 0, 0);
                    push(0, 0, 0, 0, 1);
                    halted = 1;
                end
                default: begin
                    push(0, 0, 0, 0, 0);
                    pc += 16'd4;
                end
            endcase
        end
    endtask

    // start a program and compare every cycle; inj >= 0 pulses start mid-run
    task automatic run_prog(input logic [15:0] sa, input int inj);
        int cyc = 0;
        model_run(sa);
        @(negedge clk);
        start_addr = sa;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (exp_q.size() > 0) begin
            rec_t e = exp_q.pop_front();
            chk("R4", "mem_rd", 32'(mem_rd), 32'(e.rd));
            chk("R4", "mem_wr", 32'(mem_wr), 32'(e.wr));
            if (e.rd || e.wr) chk("R3", "mem_addr", 32'(mem_addr), 32'(e.addr));
            if (e.wr) chk("R5", "mem_wdata", mem_wdata, e.wdata);
            chk("R11", "done", 32'(done), 32'(e.dn));
            chk("R9", "cond_flags", 32'(cond_flags), 32'(e.fl));
            start = (cyc == inj);
            if (cyc == inj) start_addr = 16'h0080;
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R11", "done held", 32'(done), 32'd1);
            chk("R11", "quiet after halt", 32'(mem_rd | mem_wr), 32'd0);
            chk("R11", "flags held", 32'(cond_flags), 32'(m_f));
            @(negedge clk);
        end
    endtask

    // summing loop that advances its own operand address each pass
    task automatic load_sum(input logic [15:0] b, input int n);
        poke(b + 16'h00, ins(1, 1, A_N));
        poke(b + 16'h04, ins(4, 0, 0));
        poke(b + 16'h08, ins(4, 2, 0));
        poke(b + 16'h0C, ins(3, 0, A_LIST));
        poke(b + 16'h10, ins(1, 3, b + 16'h0C));
        poke(b + 16'h14, ins(3, 3, A_FOUR));
        poke(b + 16'h18, ins(2, 3, b + 16'h0C));
        poke(b + 16'h1C, ins(3, 2, A_ONE));
        poke(b + 16'h20, ins(5, 1, 0));
        poke(b + 16'h24, ins(6, 0, b + 16'h0C));
        poke(b + 16'h28, ins(2, 0, A_SUM));
        poke(b + 16'h2C, ins(2, 2, A_CNT));
        poke(b + 16'h30, ins(0, 0, 0));
        poke(A_N, n);
        poke(A_FOUR, 4);
        poke(A_ONE, 1);
        poke(A_SUM, 32'hFFFF_FFFF);
        poke(A_CNT, 32'hFFFF_FFFF);
        for (int i = 0; i < n; i++) poke(A_LIST + 16'(4 * i), lst[i]);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog: actual hung expected halt");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] exp_sum;
        for (int i = 0; i < 128; i++) poke(16'(4 * i), 32'h0);
        for (int i = 0; i < 8; i++) m_r[i] = 0;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1", "done in reset", 32'(done), 0);
        chk("R1", "access in reset", 32'(mem_rd | mem_wr), 0);
        chk("R1", "flags in reset", 32'(cond_flags), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R1", "idle without start", 32'(mem_rd | mem_wr | done), 0);
        end

        // run 1: R12 loop, n = 5, start at 0 (R2, R10)
        lst[0] = 32'd10; lst[1] = 32'hFFFF_FFFD; lst[2] = 32'h7FFF_FFF0;
        lst[3] = 32'd20; lst[4] = 32'd7;
        load_sum(16'h0000, 5);
        run_prog(16'h0000, -1);
        exp_sum = 0;
        for (int i = 0; i < 5; i++) exp_sum += lst[i];
        chk("R12", "sum n=5", mem[A_SUM[8:2]], exp_sum);
        chk("R12", "count n=5", mem[A_CNT[8:2]], 32'd5);

        // run 2: n = 1 at 0x40, start pulse mid-run ignored (R11)
        lst[0] = 32'h8000_0001;
        load_sum(16'h0040, 1);
        run_prog(16'h0040, 6);
        chk("R12", "sum n=1", mem[A_SUM[8:2]], 32'h8000_0001);
        chk("R12", "count n=1", mem[A_CNT[8:2]], 32'd1);

        // run 3: flag corner cases at 0x80 (R6, R7, R8, R9, R10, R3)
        poke(16'h114, 32'h7FFF_FFFF);
        poke(16'h118, 32'hFFFF_FFFF);
        poke(16'h120, 32'h8000_0000);
        poke(16'h130, 32'hDEAD_BEEF);
        poke(16'h080, ins(1, 4, 16'h114));
        poke(16'h084, ins(3, 4, A_ONE));
        poke(16'h088, ins(6, 0, 16'h1F0));
        poke(16'h08C, ins(2, 4, 16'h11C));
        poke(16'h090, ins(1, 5, 16'h118));
        poke(16'h094, ins(3, 5, A_ONE));
        poke(16'h098, ins(2, 5, 16'h128));
        poke(16'h09C, ins(4, 6, 0));
        poke(16'h0A0, ins(2, 6, 16'h124));
        poke(16'h0A4, ins(5, 6, 0));
        poke(16'h0A8, ins(2, 6, 16'h12C));
        poke(16'h0AC, ins(1, 7, 16'h120));
        poke(16'h0B0, ins(5, 7, 0));
        poke(16'h0B4, ins(6, 0, 16'h0BC));
        poke(16'h0B8, ins(2, 7, 16'h130));
        poke(16'h0BC, 32'hF000_0000);
        poke(16'h0C0, ins(0, 0, 0));
        run_prog(16'h0080, -1);
        chk("R6", "add overflow result", mem[16'h11C >> 2], 32'h8000_0000);
        chk("R6", "add carry zero result", mem[16'h128 >> 2], 32'h0);
        chk("R8", "clear result", mem[16'h124 >> 2], 32'h0);
        chk("R7", "decrement across zero", mem[16'h12C >> 2], 32'hFFFF_FFFF);
        chk("R10", "taken branch skips store", mem[16'h130 >> 2], 32'hDEAD_BEEF);
        chk("R7", "flags after most-negative decrement", 32'(cond_flags), 32'b0011);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule